// File: doc/BRIEF.md
# Raster Timing Generator with Master and Slave Vertical Alignment

This block produces the line and field timing of a standard-definition video raster from a single pixel clock. It supports a 50 Hz and a 60 Hz raster. A horizontal counter spans one line. A vertical counter counts half-lines inside a field, so interlaced fields of an odd line count fall out naturally. A field counter tracks the position in a colour field sequence of 4, 8 or 12 fields. From these counters the block derives four signals: a vertical sync pulse, an odd/even field flag, a sequence-start marker, and a horizontal pulse. The horizontal pulse can optionally be gated by an active-line range, which turns it into a composite blanking signal.

Two raster outputs carry these signals. The first output carries one of vertical sync, field flag or sequence marker, selected by a register. The second output carries the horizontal pulse. Each output has its own inversion bit. In master mode the generator runs free and ignores its input pin. In slave mode, an active edge on the input pin reloads the vertical half-line counter with a programmed offset. The edge polarity is selectable. If no edges arrive in slave mode, the counters keep running exactly as in master mode.

Software writes six registers through a simple write port. A non-interlace option lengthens or shortens every field by one half-line. In that option the field flag stays low.

Top module: `raster_timer`

## Requirements
- R1: The horizontal count runs from 0 to LINE_50-1 (default 1728 clocks) when the standard bit is 0, and from 0 to LINE_60-1 (default 1716) when it is 1. A half-line boundary occurs after count LINE/2-1 and after count LINE-1.
- R2: In interlaced mode a field lasts FRAME_50 (default 625) or FRAME_60 (default 525) half-lines, so consecutive fields alternate between starting at a line start and at mid-line.
- R3: With the non-interlace bit set, every field lasts the interlaced length plus one half-line (trim bit 1) or minus one half-line (trim bit 0), and the field flag is constantly low.
- R4: Vertical sync is high for the first VS_50 (default 5) half-lines of each field at 50 Hz and the first VS_60 (default 6) at 60 Hz.
- R5: Field index 0 after reset is an odd field. The field flag is low in odd fields (even index) and high in even fields (odd index).
- R6: The sequence marker is high throughout field index 0 of a sequence whose length is 4 (select 0), 8 (select 1) or 12 (select 2 or 3).
- R7: The horizontal pulse is high while hstart <= horizontal count < hstop. When blanking is enabled, it is forced low on field lines (half-line count divided by two) below the first-line value or above the last-line value.
- R8: In slave mode, a rising edge of (input pin XOR polarity bit) reloads the half-line count with the 5-bit offset (0..31 half-lines). The reload is visible on the outputs three clocks after the pin changes. The field index is kept, and the opposite pin edge has no effect.
- R9: In master mode the input pin has no effect. In slave mode with no pin edges, the outputs equal those of master mode.
- R10: Output 1 selects vertical sync (0 or 3), field flag (1) or sequence marker (2). Each output is XORed with its own inversion bit. Outputs are registered one clock after the counter state they reflect.
- R11: Reset clears all registers and counters, giving 50 Hz interlaced master mode with both outputs low.
- R12: Register map (address: fields):
  - 0: bit0 standard 60 Hz, bit1 slave, bit2 non-interlace, bit3 trim long, bits5:4 sequence select, bits7:6 output-1 select, bit8 input polarity, bit9 output-1 invert, bit10 output-2 invert, bit11 blanking enable.
  - 1: hstart[10:0]
  - 2: hstop[10:0]
  - 3: first line[8:0]
  - 4: last line[8:0]
  - 5: offset[4:0]
  - Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| rcv_in | input | 1 | Vertical alignment input for slave mode |
| rcv1_out | output | 1 | Vertical sync, field flag or sequence marker |
| rcv2_out | output | 1 | Horizontal pulse or composite blanking |

## Verification
The hardest situation to reach from the ports is a slave reload at a known raster phase. The bench must also confirm that the field index survives the reload and that the edge of the wrong polarity is ignored. To get there, the bench runs its own arithmetic model of the raster. It waits until the model predicts a chosen half-line two clocks ahead, then moves the pin. It re-anchors the model at the predicted reload point and keeps checking every cycle. Near-exhaustive sweeps over whole field sequences use a shrunk raster (24/20-clock lines, 25/21 half-line fields), so every standard, sequence length, output selection and trim setting is covered.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_HBEG  = 3'd1;
    localparam logic [2:0] ADDR_HEND  = 3'd2;
    localparam logic [2:0] ADDR_FIRST = 3'd3;
    localparam logic [2:0] ADDR_LAST  = 3'd4;
    localparam logic [2:0] ADDR_VOFF  = 3'd5;

    localparam logic [1:0] SEL_VSYNC = 2'd0;
    localparam logic [1:0] SEL_FIELD = 2'd1;
    localparam logic [1:0] SEL_SEQ   = 2'd2;

    typedef struct packed {
        logic        std60;
        logic        slave;
        logic        nonint;
        logic        trim_long;
        logic [1:0]  seq_sel;
        logic [1:0]  r1_sel;
        logic        in_pol;
        logic        r1_inv;
        logic        r2_inv;
        logic        hblank_en;
        logic [10:0] hstart;
        logic [10:0] hstop;
        logic [8:0]  first_line;
        logic [8:0]  last_line;
        logic [4:0]  voff;
    } raster_cfg_t;

endpackage

// File: rtl/raster_cfg.sv
module raster_cfg
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    output raster_cfg_t cfg
);

    raster_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    cfg_d.std60     = wr_data[0];
                    cfg_d.slave     = wr_data[1];
                    cfg_d.nonint    = wr_data[2];
                    cfg_d.trim_long = wr_data[3];
                    cfg_d.seq_sel   = wr_data[5:4];
                    cfg_d.r1_sel    = wr_data[7:6];
                    cfg_d.in_pol    = wr_data[8];
                    cfg_d.r1_inv    = wr_data[9];
                    cfg_d.r2_inv    = wr_data[10];
                    cfg_d.hblank_en = wr_data[11];
                end
                ADDR_HBEG:  cfg_d.hstart     = wr_data[10:0];
                ADDR_HEND:  cfg_d.hstop      = wr_data[10:0];
                ADDR_FIRST: cfg_d.first_line = wr_data[8:0];
                ADDR_LAST:  cfg_d.last_line  = wr_data[8:0];
                ADDR_VOFF:  cfg_d.voff       = wr_data[4:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/raster_count.sv
module raster_count
    import raster_pkg::*;
#(
    parameter int LINE_50  = 1728,
    parameter int LINE_60  = 1716,
    parameter int FRAME_50 = 625,
    parameter int FRAME_60 = 525,
    parameter int HW       = 11,
    parameter int VW       = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  raster_cfg_t   cfg,
    input  logic          rcv_in,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vhl,
    output logic [3:0]    fld,
    output logic          slave_hit
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic [3:0]    f;
        logic          in_q;
        logic          prev_q;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [HW-1:0] len_m1, half_m1;
    logic [VW-1:0] flen_m1;
    logic [3:0]    seq_m1;
    logic          tick, hit;
    int            fbase;

    always_comb begin
        len_m1  = cfg.std60 ? HW'(LINE_60 - 1)     : HW'(LINE_50 - 1);
        half_m1 = cfg.std60 ? HW'(LINE_60 / 2 - 1) : HW'(LINE_50 / 2 - 1);
        fbase   = cfg.std60 ? FRAME_60 : FRAME_50;
        if (cfg.nonint) fbase = cfg.trim_long ? fbase + 1 : fbase - 1;
        flen_m1 = VW'(fbase - 1);
        case (cfg.seq_sel)
            2'd0:    seq_m1 = 4'd3;
            2'd1:    seq_m1 = 4'd7;
            default: seq_m1 = 4'd11;
        endcase

        hit  = cfg.slave & s_q.in_q & ~s_q.prev_q;
        tick = (s_q.h == half_m1) || (s_q.h >= len_m1);

        s_d        = s_q;
        s_d.in_q   = rcv_in ^ cfg.in_pol;
        s_d.prev_q = s_q.in_q;
        s_d.h      = (s_q.h >= len_m1) ? '0 : s_q.h + 1'b1;
        if (hit) begin
            s_d.v = VW'(cfg.voff);
        end else if (tick) begin
            if (s_q.v >= flen_m1) begin
                s_d.v = '0;
                s_d.f = (s_q.f >= seq_m1) ? 4'd0 : s_q.f + 4'd1;
            end else begin
                s_d.v = s_q.v + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hcnt      = s_q.h;
    assign vhl       = s_q.v;
    assign fld       = s_q.f;
    assign slave_hit = hit;

endmodule

// File: rtl/raster_out.sv
module raster_out
    import raster_pkg::*;
#(
    parameter int VS_50 = 5,
    parameter int VS_60 = 6,
    parameter int HW    = 11,
    parameter int VW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  raster_cfg_t   cfg,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vhl,
    input  logic [3:0]    fld,
    output logic          rcv1_out,
    output logic          rcv2_out
);

    typedef struct packed {
        logic r1;
        logic r2;
    } out_t;

    out_t o_d, o_q;
    logic vsync, field_flag, seq_mark, sel_val, hpulse;
    int   line_idx;

    always_comb begin
        vsync      = int'(vhl) < (cfg.std60 ? VS_60 : VS_50);
        field_flag = ~cfg.nonint & fld[0];
        seq_mark   = (fld == 4'd0);
        case (cfg.r1_sel)
            SEL_FIELD: sel_val = field_flag;
            SEL_SEQ:   sel_val = seq_mark;
            default:   sel_val = vsync;
        endcase

        line_idx = int'(vhl >> 1);
        hpulse   = (int'(hcnt) >= int'(cfg.hstart)) && (int'(hcnt) < int'(cfg.hstop));
        if (cfg.hblank_en &&
            ((line_idx < int'(cfg.first_line)) || (line_idx > int'(cfg.last_line))))
            hpulse = 1'b0;

        o_d.r1 = sel_val ^ cfg.r1_inv;
        o_d.r2 = hpulse ^ cfg.r2_inv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rcv1_out = o_q.r1;
    assign rcv2_out = o_q.r2;

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int LINE_50  = 1728,
    parameter int LINE_60  = 1716,
    parameter int FRAME_50 = 625,
    parameter int FRAME_60 = 525,
    parameter int VS_50    = 5,
    parameter int VS_60    = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        rcv_in,
    output logic        rcv1_out,
    output logic        rcv2_out
);

    localparam int LMAX = (LINE_50 > LINE_60) ? LINE_50 : LINE_60;
    localparam int FMAX = (FRAME_50 > FRAME_60) ? FRAME_50 : FRAME_60;
    localparam int HW   = $clog2(LMAX);
    localparam int VW0  = $clog2(FMAX + 2);
    localparam int VW   = (VW0 < 5) ? 5 : VW0;

    raster_cfg_t   cfg_q;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vhl;
    logic [3:0]    fld;
    logic          slave_hit;

    raster_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg_q)
    );

    raster_count #(
        .LINE_50 (LINE_50), .LINE_60 (LINE_60),
        .FRAME_50(FRAME_50), .FRAME_60(FRAME_60),
        .HW      (HW), .VW (VW)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_q),
        .rcv_in    (rcv_in),
        .hcnt      (hcnt),
        .vhl       (vhl),
        .fld       (fld),
        .slave_hit (slave_hit)
    );

    raster_out #(
        .VS_50 (VS_50), .VS_60 (VS_60),
        .HW    (HW), .VW (VW)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .hcnt     (hcnt),
        .vhl      (vhl),
        .fld      (fld),
        .rcv1_out (rcv1_out),
        .rcv2_out (rcv2_out)
    );

endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk
    import raster_pkg::*;
#(
    parameter int LINE_50 = 1728,
    parameter int LINE_60 = 1716,
    parameter int HW      = 11,
    parameter int VW      = 10
) (
    input logic          clk,
    input logic          rst_n,
    input raster_cfg_t   cfg,
    input logic [HW-1:0] h,
    input logic [VW-1:0] v,
    input logic          hit,
    input logic          rcv1_out,
    input logic          rcv2_out
);

    // R1
    hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg.std60) |-> int'(h) < (cfg.std60 ? LINE_60 : LINE_50));

    // R1
    hcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h != '0) |-> (int'(h) == int'($past(h)) + 1));

    // R2
    vhl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(v) || (h == '0) ||
                  (int'(h) == ($past(cfg.std60) ? LINE_60 / 2 : LINE_50 / 2))));

    // R8
    slave_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (int'(v) == int'($past(cfg.voff))));

    // R3
    nonint_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.nonint && cfg.r1_sel == SEL_FIELD && !cfg.r1_inv) |=> !rcv1_out);

    // R7
    hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hblank_en && !cfg.r2_inv && (int'(v >> 1) < int'(cfg.first_line)))
        |=> !rcv2_out);

endmodule

bind raster_timer raster_timer_chk #(
    .LINE_50 (LINE_50), .LINE_60 (LINE_60), .HW (HW), .VW (VW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .h        (hcnt),
    .v        (vhl),
    .hit      (slave_hit),
    .rcv1_out (rcv1_out),
    .rcv2_out (rcv2_out)
);

// File: tb/raster_timer_tb.sv
module raster_timer_tb;

    localparam int L50 = 24;
    localparam int L60 = 20;
    localparam int N50 = 25;
    localparam int N60 = 21;
    localparam int V50 = 5;
    localparam int V60 = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rcv_in = 1'b0;
    logic        rcv1_out, rcv2_out;

    int     checks = 0;
    int     errors = 0;
    longint ecnt = 0;
    bit     done = 1'b0;

    bit     m_std60, m_slave, m_nonint, m_long, m_inpol, m_inv1, m_inv2, m_blank;
    int     m_seq, m_sel, m_hs, m_he, m_first, m_last, m_voff;
    longint a_pos, a_half, a_fld;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    raster_timer #(
        .LINE_50(L50), .LINE_60(L60), .FRAME_50(N50), .FRAME_60(N60),
        .VS_50(V50), .VS_60(V60)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rcv_in(rcv_in),
        .rcv1_out(rcv1_out), .rcv2_out(rcv2_out)
    );

    function automatic longint line_len();
        return m_std60 ? L60 : L50;
    endfunction

    function automatic longint fld_len();
        longint b;
        b = m_std60 ? N60 : N50;
        if (m_nonint) b = m_long ? b + 1 : b - 1;
        return b;
    endfunction

    function automatic longint seq_len();
        return (m_seq == 0) ? 4 : (m_seq == 1) ? 8 : 12;
    endfunction

    function automatic longint tot_half(longint p);
        longint hh;
        hh = line_len() / 2;
        return a_half + p / hh - a_pos / hh;
    endfunction

    function automatic longint vpos(longint p);
        return tot_half(p) % fld_len();
    endfunction

    function automatic longint fidx(longint p);
        return (a_fld + tot_half(p) / fld_len()) % seq_len();
    endfunction

    function automatic logic [1:0] expect_out(longint p);
        longint v, f, hc;
        logic   vs, oe, fs, s1, hp;
        v  = vpos(p);
        f  = fidx(p);
        hc = p % line_len();
        vs = v < (m_std60 ? V60 : V50);
        oe = !m_nonint && (f % 2 == 1);
        fs = (f == 0);
        s1 = (m_sel == 1) ? oe : (m_sel == 2) ? fs : vs;
        hp = (hc >= m_hs) && (hc < m_he);
        if (m_blank && ((v / 2 < m_first) || (v / 2 > m_last))) hp = 1'b0;
        return {s1 ^ m_inv1, hp ^ m_inv2};
    endfunction

    task automatic check(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            if (errors <= 30)
                $display("FAIL %s %s: got %b expected %b (edge %0d)", tag, what, got, exp, ecnt);
        end
    endtask

    task automatic window(string tag1, string tag2, int n, bit toggle);
        logic [1:0] e;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (toggle && (i % 7 == 0)) rcv_in = ~rcv_in;
            e = expect_out(ecnt - 1);
            check(tag1, "rcv1_out", rcv1_out, e[1]);
            check(tag2, "rcv2_out", rcv2_out, e[0]);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ctrl();
        wr(3'd0, {4'b0, m_blank, m_inv2, m_inv1, m_inpol, 2'(m_sel), 2'(m_seq),
                  m_long, m_nonint, m_slave, m_std60});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rcv_in = 1'b0;
        {m_std60, m_slave, m_nonint, m_long, m_inpol, m_inv1, m_inv2, m_blank} = '0;
        m_seq = 0; m_sel = 0; m_hs = 0; m_he = 0; m_first = 0; m_last = 0; m_voff = 0;
        a_pos = 0; a_half = 0; a_fld = 0;
        repeat (3) @(negedge clk);
        // R11: outputs low during reset
        check("R11", "rcv1_out in reset", rcv1_out, 1'b0);
        check("R11", "rcv2_out in reset", rcv2_out, 1'b0);
        rst_n = 1'b1;
    endtask

    // ctrl is written first so the counters see the new standard from position 1
    task automatic setup(bit std, bit nonint, bit lng, int seq, int sel, bit i1, bit i2,
                         bit blank, int hs, int he, int fl, int ll, bit slave, int voff);
        do_reset();
        m_std60 = std; m_nonint = nonint; m_long = lng; m_seq = seq; m_sel = sel;
        m_inv1 = i1; m_inv2 = i2; m_blank = blank; m_slave = slave;
        m_hs = hs; m_he = he; m_first = fl; m_last = ll; m_voff = voff;
        wr_ctrl();
        wr(3'd1, 16'(hs));
        wr(3'd2, 16'(he));
        wr(3'd3, 16'(fl));
        wr(3'd4, 16'(ll));
        wr(3'd5, 16'(voff));
        wr(3'd7, 16'hffff);   // R12: unmapped address ignored
    endtask

    // move pin once the model predicts half-line 'target' two clocks ahead
    task automatic trigger(int target, logic level);
        longint e, nf;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (vpos(ecnt + 2) == target) break;
        end
        e  = ecnt;
        nf = fidx(e + 1);
        a_pos = e + 2; a_half = m_voff; a_fld = nf;
        rcv_in = level;
    endtask

    initial begin
        // R11: default state after reset, no writes
        do_reset();
        window("R11", "R11", 600, 1'b0);

        // R4 / R1: 50 Hz vsync and horizontal pulse
        setup(0, 0, 0, 0, 0, 0, 0, 0, 3, 9, 0, 0, 0, 0);
        window("R4", "R1", 4 * N50 * (L50 / 2) + 20, 1'b0);

        // R5 / R7: 60 Hz field flag, blanking gate
        setup(1, 0, 0, 1, 1, 0, 0, 1, 0, 5, 2, 8, 0, 0);
        window("R5", "R7", 8 * N60 * (L60 / 2) + 20, 1'b0);

        // R6 / R7: 50 Hz 12-field sequence marker
        setup(0, 0, 0, 2, 2, 0, 0, 1, 10, 23, 0, 3, 0, 0);
        window("R6", "R7", 12 * N50 * (L50 / 2) + 20, 1'b0);

        // R6 / R2: 60 Hz, select code 3 also gives 12 fields
        setup(1, 0, 0, 3, 2, 0, 0, 0, 1, 19, 0, 0, 0, 0);
        window("R6", "R2", 12 * N60 * (L60 / 2) + 20, 1'b0);

        // R3: non-interlace long fields, flag stays low
        setup(0, 1, 1, 0, 1, 0, 0, 0, 0, 12, 0, 0, 0, 0);
        window("R3", "R2", 4 * (N50 + 1) * (L50 / 2) + 20, 1'b0);

        // R3 / R10: non-interlace short fields, both outputs inverted
        setup(1, 1, 0, 1, 0, 1, 1, 0, 4, 12, 0, 0, 0, 0);
        window("R3", "R10", 8 * (N60 - 1) * (L60 / 2) + 20, 1'b0);

        // R9: master mode ignores a toggling input pin
        setup(0, 0, 0, 0, 0, 0, 0, 0, 2, 6, 0, 0, 0, 0);
        window("R9", "R9", 1300, 1'b1);

        // R9: slave without edges runs free like master
        setup(0, 0, 0, 0, 0, 0, 0, 0, 2, 6, 0, 0, 1, 12);
        window("R9", "R9", 700, 1'b0);

        // R8: rising pin edge in vsync reloads offset 12, vsync drops
        trigger(2, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check("R8", "vsync before reload", rcv1_out, 1'b1);
        @(negedge clk);
        check("R8", "vsync after reload", rcv1_out, 1'b0);
        window("R8", "R8", 700, 1'b0);

        // R8: polarity 1, falling pin edge reloads offset 0
        m_inpol = 1'b1;
        wr_ctrl();
        m_voff = 0;
        wr(3'd5, 16'd0);
        window("R8", "R8", 100, 1'b0);
        trigger(20, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R8", "vsync before falling reload", rcv1_out, 1'b0);
        @(negedge clk);
        check("R8", "vsync after falling reload", rcv1_out, 1'b1);
        window("R8", "R8", 700, 1'b0);

        // R8: rising pin with polarity 1 is not an active edge
        @(negedge clk);
        rcv_in = 1'b1;
        window("R8", "R8", 700, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule